// File: doc/BRIEF.md
# Fractional-Rate PWM with Staged Reconfiguration

This block generates one pulse-width-modulated output from a 16-bit phase accumulator. On every clock while the channel runs, the accumulator grows by a rate step. The step is an 8.8 fixed-point value with an 8-bit integer part and an 8-bit fraction, so the output frequency is the clock frequency times the step divided by 256. The output is high while the accumulator's top byte is at or above an 8-bit on-time divisor. The high fraction of each period is therefore (256 − divisor)/256.

Software reaches the block through a small memory-mapped bus that exposes a 32-bit control word and a separate reset register. A write to the control word changes only staging copies of the rate step and the divisor. A second write sets a request bit. Hardware then moves the staged values into the active copies: at the next accumulator wrap if the channel runs, or on the next clock if it is stopped. Hardware clears the request bit in that same clock, so software polls until the request bit reads zero or the enable bit reads zero. Writing the key value 3 to the reset register returns all state to zero.

Top module: `acc_pwm`

## Requirements
- R1: Reading the control word at offset 0x000 returns the staged divisor in bits 7:0, the staged integer step in bits 15:8, the staged fraction step in bits 23:16, zeros in bits 29:24, the request bit in bit 30 and the enable bit in bit 31. Reads return staged fields, never the active ones.
- R2: A write to offset 0x000 loads bits 23:0 into the staged fields and bit 31 into the enable. Writes to any other offset, except the reset register, have no effect. Reads of any offset other than 0x000 return zero.
- R3: While enabled, the accumulator grows by (integer step × 256 + fraction step) on every clock, modulo 65536. The output period is therefore 65536 divided by that step, in cycles.
- R4: The output is high exactly when the channel is enabled and the accumulator's top byte is greater than or equal to the active divisor. At step 1.0 (0x0100) each 256-cycle period has 256 − divisor high cycles, and a divisor of 0 keeps the output high.
- R5: Staged values written without a request leave the output and the active values unchanged.
- R6: Writing 1 to bit 30 sets the request. Writing 0 to bit 30 does not cancel a pending request.
- R7: While enabled, a pending request is applied at the clock edge where the accumulator wraps, and the request bit clears at that same edge.
- R8: While disabled, a pending request is applied on the next clock edge and the request bit clears at that edge.
- R9: With enable at 0 the output is low and the accumulator is held at zero, so re-enabling starts a fresh period from phase zero.
- R10: Writing the value 3 to offset 0x804 clears the staged and active fields, the enable and the request. Writing any other value there has no effect.
- R11: After the hardware reset input is released, the control word reads zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the accumulator advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for a read access, combinational |
| pwm_o | output | 1 | Pulse-width-modulated output |

## Verification
The bench sweeps the divisor across its extremes and middle values at a whole-number step. It counts high cycles per period, so a compare written as strict greater-than, or one that takes the divisor from the staged copy, gives a count off by one or reacts to an unrequested write. It measures the period at several steps and runs a fractional step against a cycle-by-cycle arithmetic model, so a lost carry between the fraction and integer halves shows up as a wrong waveform. Requests are issued while the channel runs, while it is stopped and while a request is already pending, with a bit-30 write of zero in between. A design that applies a request at once, fails to wait for the wrap, or lets a zero write cancel the request shows the request bit or the output changing in the wrong cycle. Reset-register writes with a wrong key and with the right key confirm that only the value 3 clears the block.

// File: rtl/acc_pwm_pkg.sv
package acc_pwm_pkg;

    localparam int DIV_W  = 8;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 8;
    localparam int ACC_W  = INT_W + FRAC_W;
    localparam int CFG_W  = DIV_W + INT_W + FRAC_W;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;

    localparam int EN_BIT  = 31;
    localparam int REQ_BIT = 30;

    localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h000;
    localparam logic [ADDR_W-1:0] KILL_OFS = 12'h804;
    localparam logic [WORD_W-1:0] KILL_KEY = 32'd3;

    // Packed so that the struct lines up with control word bits 23:0.
    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic [INT_W-1:0]  whole;
        logic [DIV_W-1:0]  div;
    } pwm_cfg_t;

    function automatic logic [ACC_W-1:0] cfg_step(input pwm_cfg_t c);
        return {c.whole, c.frac};
    endfunction

endpackage

// File: rtl/acc_pwm_regs.sv
module acc_pwm_regs
    import acc_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              apply_i,
    output pwm_cfg_t          stage_o,
    output logic              en_o,
    output logic              req_o,
    output logic              kill_o,
    output logic [WORD_W-1:0] bus_rdata
);

    typedef struct packed {
        pwm_cfg_t stage;
        logic     en;
        logic     req;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_wr;
    logic  kill_hit;

    always_comb begin
        ctrl_wr  = bus_sel && bus_wr && (bus_addr == CTRL_OFS);
        kill_hit = bus_sel && bus_wr && (bus_addr == KILL_OFS) && (bus_wdata == KILL_KEY);

        regs_d = regs_q;
        if (apply_i) begin
            regs_d.req = 1'b0;
        end
        if (ctrl_wr) begin
            regs_d.stage = pwm_cfg_t'(bus_wdata[CFG_W-1:0]);
            regs_d.en    = bus_wdata[EN_BIT];
            if (bus_wdata[REQ_BIT]) begin
                regs_d.req = 1'b1;
            end
        end
        if (kill_hit) begin
            regs_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && (bus_addr == CTRL_OFS)) begin
            bus_rdata[CFG_W-1:0] = regs_q.stage;
            bus_rdata[REQ_BIT]   = regs_q.req;
            bus_rdata[EN_BIT]    = regs_q.en;
        end
    end

    assign stage_o = regs_q.stage;
    assign en_o    = regs_q.en;
    assign req_o   = regs_q.req;
    assign kill_o  = kill_hit;

endmodule

// File: rtl/acc_pwm_shadow.sv
module acc_pwm_shadow
    import acc_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     kill_i,
    input  pwm_cfg_t stage_i,
    input  logic     en_i,
    input  logic     req_i,
    input  logic     wrap_i,
    output pwm_cfg_t act_o,
    output logic     apply_o
);

    typedef struct packed {
        pwm_cfg_t act;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic    apply;

    always_comb begin
        apply = req_i && (!en_i || wrap_i);
        sh_d  = sh_q;
        if (apply) begin
            sh_d.act = stage_i;
        end
        if (kill_i) begin
            sh_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign act_o   = sh_q.act;
    assign apply_o = apply;

endmodule

// File: rtl/acc_pwm_core.sv
module acc_pwm_core
    import acc_pwm_pkg::*;
#(
    parameter int PHASE_W = ACC_W,
    parameter int CMP_W   = DIV_W,
    localparam int TOP_LSB = PHASE_W - CMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill_i,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] step_i,
    input  logic [CMP_W-1:0]   div_i,
    output logic               wrap_o,
    output logic [PHASE_W-1:0] acc_o,
    output logic               pwm_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } core_t;

    core_t            core_d, core_q;
    logic [PHASE_W:0] sum;

    always_comb begin
        sum    = {1'b0, core_q.acc} + {1'b0, step_i};
        core_d = core_q;
        if (en_i) begin
            core_d.acc = sum[PHASE_W-1:0];
        end else begin
            core_d.acc = '0;
        end
        if (kill_i) begin
            core_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign wrap_o = en_i && sum[PHASE_W];
    assign acc_o  = core_q.acc;
    assign pwm_o  = en_i && (core_q.acc[PHASE_W-1:TOP_LSB] >= div_i);

endmodule

// File: rtl/acc_pwm.sv
module acc_pwm
    import acc_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              pwm_o
);

    pwm_cfg_t         stage_w;
    pwm_cfg_t         act_w;
    logic             en_w;
    logic             req_w;
    logic             kill_w;
    logic             apply_w;
    logic             wrap_w;
    logic [ACC_W-1:0] acc_w;

    acc_pwm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .apply_i   (apply_w),
        .stage_o   (stage_w),
        .en_o      (en_w),
        .req_o     (req_w),
        .kill_o    (kill_w),
        .bus_rdata (bus_rdata)
    );

    acc_pwm_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill_i  (kill_w),
        .stage_i (stage_w),
        .en_i    (en_w),
        .req_i   (req_w),
        .wrap_i  (wrap_w),
        .act_o   (act_w),
        .apply_o (apply_w)
    );

    acc_pwm_core #(
        .PHASE_W (ACC_W),
        .CMP_W   (DIV_W)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill_i (kill_w),
        .en_i   (en_w),
        .step_i (cfg_step(act_w)),
        .div_i  (act_w.div),
        .wrap_o (wrap_w),
        .acc_o  (acc_w),
        .pwm_o  (pwm_o)
    );

endmodule

// File: rtl/acc_pwm_chk.sv
module acc_pwm_chk
    import acc_pwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input pwm_cfg_t          stage_w,
    input pwm_cfg_t          act_w,
    input logic              en_w,
    input logic              req_w,
    input logic              kill_w,
    input logic              wrap_w,
    input logic [ACC_W-1:0]  acc_w,
    input logic              pwm_o
);

    logic req_set;
    assign req_set = bus_sel && bus_wr && (bus_addr == CTRL_OFS) && bus_wdata[REQ_BIT];

    // R9
    idle_acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_w && $past(!en_w)) |-> (acc_w == '0));

    // R8
    idle_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_w && !en_w && !req_set) |=> !req_w);

    // R7
    hold_until_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_w && en_w && !wrap_w && !kill_w) |=> $stable(act_w));

    // R5
    act_only_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_w) |-> ($past(req_w) || $past(kill_w)));

    // R10
    kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_w |=> (stage_w == '0 && act_w == '0 && !en_w && !req_w && acc_w == '0));

    // R4
    zero_div_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && act_w.div == '0) |-> pwm_o);

endmodule

bind acc_pwm acc_pwm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stage_w   (stage_w),
    .act_w     (act_w),
    .en_w      (en_w),
    .req_w     (req_w),
    .kill_w    (kill_w),
    .wrap_w    (wrap_w),
    .acc_w     (acc_w),
    .pwm_o     (pwm_o)
);

// File: tb/test_acc_pwm.sv
module test_acc_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R11";

    // reference model state
    logic [23:0] m_stage = '0;
    logic [23:0] m_act = '0;
    logic        m_en = 1'b0;
    logic        m_req = 1'b0;
    logic [15:0] m_acc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_pwm i_acc_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic model_pwm();
        return m_en && (m_acc[15:8] >= m_act[7:0]);
    endfunction

    // One clock: drive an access, advance the model, then compare at the ports.
    task automatic tick(input logic wr, input logic [11:0] addr, input logic [31:0] data);
        logic [16:0] sum;
        logic        wrap, apply, kill, wctl;
        logic [23:0] n_stage, n_act;
        logic        n_en, n_req;
        logic [15:0] n_acc;
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        sum   = {1'b0, m_acc} + {1'b0, m_act[15:8], m_act[23:16]};
        wrap  = m_en && sum[16];
        apply = m_req && (!m_en || wrap);
        kill  = wr && (addr == 12'h804) && (data == 32'd3);
        wctl  = wr && (addr == 12'h000);
        n_acc   = m_en ? sum[15:0] : 16'h0;
        n_act   = apply ? m_stage : m_act;
        n_req   = apply ? 1'b0 : m_req;
        n_stage = m_stage;
        n_en    = m_en;
        if (wctl) begin
            n_stage = data[23:0];
            n_en    = data[31];
            if (data[30]) n_req = 1'b1;
        end
        if (kill) begin
            n_stage = '0; n_act = '0; n_en = 1'b0; n_req = 1'b0; n_acc = '0;
        end
        @(posedge clk);
        m_stage = n_stage; m_act = n_act; m_en = n_en; m_req = n_req; m_acc = n_acc;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h000; bus_wdata = '0;
        #1;
        check(pwm_o === model_pwm(), {cur_tag, " pwm"}, {31'd0, pwm_o}, {31'd0, model_pwm()});
        check(bus_rdata === {m_en, m_req, 6'd0, m_stage}, {cur_tag, " ctrl"},
              bus_rdata, {m_en, m_req, 6'd0, m_stage});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 12'h000, 32'h0);
    endtask

    // Stage and apply a configuration while stopped, leaving the channel off.
    task automatic load_cfg(input logic [23:0] cfg);
        tick(1'b1, 12'h000, {2'b01, 6'd0, cfg});
        tick(1'b0, 12'h000, 32'h0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int highs;
        int first_rise;
        int period;
        logic prev;
        logic [7:0] divs [6];
        divs[0] = 8'd0;  divs[1] = 8'd1;   divs[2] = 8'd64;
        divs[3] = 8'd128; divs[4] = 8'd200; divs[5] = 8'd255;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h000;
        #1;
        // R11 reset state
        check(bus_rdata === 32'h0, "R11 ctrl after reset", bus_rdata, 32'h0);
        check(pwm_o === 1'b0, "R11 pwm after reset", {31'd0, pwm_o}, 32'd0);

        // R1: field layout and reserved bits read zero
        cur_tag = "R1";
        tick(1'b1, 12'h000, 32'h3F123456);
        check(bus_rdata === 32'h00123456, "R1 readback layout", bus_rdata, 32'h00123456);

        // R2: stray offset ignored, other offsets read zero
        cur_tag = "R2";
        tick(1'b1, 12'h010, 32'hFFFFFFFF);
        check(bus_rdata === 32'h00123456, "R2 stray write ignored", bus_rdata, 32'h00123456);
        bus_addr = 12'h804; #1;
        check(bus_rdata === 32'h0, "R2 reset reg reads zero", bus_rdata, 32'h0);
        bus_addr = 12'h000; #1;

        // R8: request applied on next clock while stopped
        cur_tag = "R8";
        tick(1'b1, 12'h000, 32'h40123456);
        check(bus_rdata[30] === 1'b1, "R8 request visible", {31'd0, bus_rdata[30]}, 32'd1);
        tick(1'b0, 12'h000, 32'h0);
        check(bus_rdata[30] === 1'b0, "R8 request cleared next clock", {31'd0, bus_rdata[30]}, 32'd0);

        // R4 sweep of the divisor at step 1.0
        for (int k = 0; k < 6; k++) begin
            cur_tag = "R4";
            load_cfg({8'h00, 8'h01, divs[k]});
            tick(1'b1, 12'h000, {8'h80, 8'h00, 8'h01, divs[k]});
            highs = int'(pwm_o);
            for (int c = 0; c < 255; c++) begin
                tick(1'b0, 12'h000, 32'h0);
                highs += int'(pwm_o);
            end
            check(highs == 256 - int'(divs[k]), "R4 high cycles per period",
                  32'(highs), 32'(256 - int'(divs[k])));
            // R9: stopping forces low and zero phase
            cur_tag = "R9";
            tick(1'b1, 12'h000, {8'h00, 8'h00, 8'h01, divs[k]});
            idle(2);
            check(pwm_o === 1'b0, "R9 low when stopped", {31'd0, pwm_o}, 32'd0);
        end

        // R3: period at integer steps 2.0 and 64.0
        for (int s = 0; s < 2; s++) begin
            logic [7:0] whole;
            int exp_p;
            whole = (s == 0) ? 8'h02 : 8'h40;
            exp_p = (s == 0) ? 128 : 4;
            cur_tag = "R3";
            load_cfg({8'h00, whole, 8'h80});
            tick(1'b1, 12'h000, {8'h80, 8'h00, whole, 8'h80});
            first_rise = -1; period = -1; prev = pwm_o;
            for (int c = 1; c < 400 && period < 0; c++) begin
                tick(1'b0, 12'h000, 32'h0);
                if (pwm_o && !prev) begin
                    if (first_rise < 0) first_rise = c;
                    else period = c - first_rise;
                end
                prev = pwm_o;
            end
            check(period == exp_p, "R3 period at integer step", 32'(period), 32'(exp_p));
            tick(1'b1, 12'h000, 32'h0);
        end

        // R3: fractional step 1.5 against the model
        cur_tag = "R3";
        load_cfg({8'h80, 8'h01, 8'h40});
        tick(1'b1, 12'h000, {8'h80, 8'h80, 8'h01, 8'h40});
        idle(600);

        // R5: staged change without request does nothing
        cur_tag = "R5";
        load_cfg({8'h00, 8'h10, 8'h80});
        tick(1'b1, 12'h000, {8'h80, 8'h00, 8'h10, 8'h80});
        idle(5);
        tick(1'b1, 12'h000, {8'h80, 8'h00, 8'h20, 8'h20});
        idle(40);

        // R7: request applied at the wrap, bit clears then
        cur_tag = "R7";
        tick(1'b1, 12'h000, {8'hC0, 8'h00, 8'h20, 8'h20});
        check(bus_rdata[30] === 1'b1, "R7 request pending until wrap", {31'd0, bus_rdata[30]}, 32'd1);
        idle(40);
        check(bus_rdata[30] === 1'b0, "R7 request applied", {31'd0, bus_rdata[30]}, 32'd0);

        // R6: writing zero to the request bit keeps a pending request
        cur_tag = "R6";
        load_cfg({8'h00, 8'h01, 8'h80});
        tick(1'b1, 12'h000, {8'h80, 8'h00, 8'h01, 8'h80});
        idle(3);
        tick(1'b1, 12'h000, {8'hC0, 8'h00, 8'h02, 8'h40});
        idle(2);
        tick(1'b1, 12'h000, {8'h80, 8'h00, 8'h04, 8'h10});
        check(bus_rdata[30] === 1'b1, "R6 zero write keeps request", {31'd0, bus_rdata[30]}, 32'd1);
        idle(300);
        check(bus_rdata[30] === 1'b0, "R6 request later applied", {31'd0, bus_rdata[30]}, 32'd0);

        // R9: restart from phase zero after a stop
        cur_tag = "R9";
        tick(1'b1, 12'h000, {8'h00, 8'h00, 8'h04, 8'h10});
        idle(3);
        tick(1'b1, 12'h000, {8'h80, 8'h00, 8'h04, 8'h10});
        idle(100);

        // R10: wrong key ignored, right key clears
        cur_tag = "R10";
        tick(1'b1, 12'h804, 32'd5);
        check(bus_rdata === 32'h80000410, "R10 wrong key ignored", bus_rdata, 32'h80000410);
        tick(1'b1, 12'h804, 32'd3);
        check(bus_rdata === 32'h0, "R10 key clears control", bus_rdata, 32'h0);
        check(pwm_o === 1'b0, "R10 output low after clear", {31'd0, pwm_o}, 32'd0);
        idle(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule